// File: doc/BRIEF.md
# 8-bit Arithmetic Unit with Status Flags

This block is the arithmetic datapath for an accumulator-style processor. It combines the accumulator with a second byte to produce an 8-bit result in the same cycle. The second byte may come from a register, from memory or from an immediate field; the arithmetic does not depend on where it came from. The block supports six operations: plain add, add with carry-in, plain subtract, subtract with borrow-in, increment and decrement.

The block keeps five status flags in one byte register: sign, zero, nibble (auxiliary) carry, parity and carry. On subtraction the carry flag acts as a borrow flag. The register loads on a rising clock edge only when the execute strobe is high and the operation code is one that sets flags. Increment and decrement act on the second operand alone. They never change the carry flag. The carry-in for add-with-carry and subtract-with-borrow comes from the stored carry flag.

Top module: `alu8_unit`

## Requirements
- R1: While reset is asserted and just after it, the flag byte reads 02h: all five flags are clear and bit 1 holds its fixed one.
- R2: The code 0 (add) gives res = acc + opnd mod 256. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R3: The code 1 (add with carry) gives res = acc + opnd + CY. It uses the stored CY flag, and it sets CY and AC the way code 0 does.
- R4: The code 2 (subtract) gives res = acc − opnd mod 256. CY is set when opnd > acc, unsigned. AC is set when the low nibble of opnd is greater than the low nibble of acc.
- R5: The code 3 (subtract with borrow) gives res = acc − opnd − CY. CY is set when opnd + CY > acc. AC is set when opnd[3:0] + CY > acc[3:0].
- R6: The code 4 (increment) gives res = opnd + 1 with AC = (opnd[3:0] == Fh). The code 5 (decrement) gives res = opnd − 1 with AC = (opnd[3:0] == 0h). Both leave CY at its previous value.
- R7: After any flag write, S is result bit 7 and Z is set when the result is 00h. P is set when the result holds an even number of ones.
- R8: In the flag byte, S sits at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1.
- R9: The flag byte changes only at a rising edge where exec_en is 1 and the code is 0 to 5. If exec_en is 0, or the code is 6 or 7, the flags keep their value. Codes 6 and 7 also pass acc through to res.
- R10: res is combinational. It follows the present inputs and the stored CY without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| exec_en | input | 1 | Strobe that lets the current operation write the flags |
| op_code | input | 3 | Operation: 0 add, 1 add+CY, 2 sub, 3 sub−CY, 4 inc, 5 dec |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand, from a register, memory or an immediate |
| res_out | output | 8 | Arithmetic result |
| flags_out | output | 8 | Stored flag byte |

## Verification
The hardest cases to reach are the ones where the stored carry feeds back into the arithmetic. In those cases a one-bit borrow or carry moves a nibble or byte boundary. Examples are a subtract-with-borrow whose operand equals the accumulator exactly, and an increment that wraps to zero while carry must stay set. The stimulus first runs an operation that puts CY in the needed state. It then runs the dependent operation and checks the result at once and the flag byte after the edge. Gating is checked by offering operations that would change every flag while the strobe is low or the code is unused.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBB = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  // bit positions inside the flag byte
  localparam int unsigned FB_S  = 7;
  localparam int unsigned FB_Z  = 6;
  localparam int unsigned FB_AC = 4;
  localparam int unsigned FB_P  = 2;
  localparam int unsigned FB_CY = 0;

  // value of the flag byte with every flag clear
  localparam logic [7:0] FLAGS_IDLE = 8'h02;

endpackage

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic             cy_in,
  output logic [DW-1:0]    res,
  output logic             cy_out,
  output logic             ac_out,
  output logic             flag_wr
);

  localparam int unsigned HALF = DW / 2;
  localparam logic [DW:0]   ONE_W = {{DW{1'b0}}, 1'b1};
  localparam logic [HALF:0] ONE_H = {{HALF{1'b0}}, 1'b1};

  logic [DW:0]   wide;
  logic [HALF:0] low;
  logic [DW:0]   cin_w;
  logic [HALF:0] cin_h;
  logic          use_cy;

  always_comb begin
    use_cy = (op == OP_ADDC) || (op == OP_SUBB);
    cin_w  = {{DW{1'b0}}, use_cy & cy_in};
    cin_h  = {{HALF{1'b0}}, use_cy & cy_in};
    wide   = {1'b0, a};
    low    = {1'b0, a[HALF-1:0]};
    unique case (op)
      OP_ADD, OP_ADDC: begin
        wide = {1'b0, a} + {1'b0, b} + cin_w;
        low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + cin_h;
      end
      OP_SUB, OP_SUBB: begin
        wide = {1'b0, a} - {1'b0, b} - cin_w;
        low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - cin_h;
      end
      OP_INC: begin
        wide = {1'b0, b} + ONE_W;
        low  = {1'b0, b[HALF-1:0]} + ONE_H;
      end
      OP_DEC: begin
        wide = {1'b0, b} - ONE_W;
        low  = {1'b0, b[HALF-1:0]} - ONE_H;
      end
      default: begin
        wide = {1'b0, a};
        low  = {HALF+1{1'b0}};
      end
    endcase
    res     = wide[DW-1:0];
    ac_out  = low[HALF];
    flag_wr = (op != OP_RSV6) && (op != OP_RSV7);
    cy_out  = ((op == OP_INC) || (op == OP_DEC)) ? cy_in : wide[DW];
  end

endmodule

// File: rtl/alu8_flaggen.sv
module alu8_flaggen
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] res,
  input  logic          cy,
  input  logic          ac,
  output logic [7:0]    flags
);

  always_comb begin
    flags        = FLAGS_IDLE;
    flags[FB_S]  = res[DW-1];
    flags[FB_Z]  = (res == '0);
    flags[FB_AC] = ac;
    flags[FB_P]  = ~(^res);
    flags[FB_CY] = cy;
  end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] d,
  output logic [7:0] q
);

  logic [7:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= FLAGS_IDLE;
    else        q <= q_nxt;
  end

  // R9: no write strobe, no change
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

  // R8: filler bits never move
  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q[5] == 1'b0) && (q[3] == 1'b0) && (q[1] == 1'b1));

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] opnd_in,
  output logic [DW-1:0] res_out,
  output logic [7:0]    flags_out
);

  alu_op_e    op;
  logic       cy_next;
  logic       ac_next;
  logic       op_writes;
  logic [7:0] flags_next;
  logic       flag_we;

  assign op      = alu_op_e'(op_code);
  assign flag_we = exec_en & op_writes;

  alu8_core #(.DW(DW)) u_core (
    .op      (op),
    .a       (acc_in),
    .b       (opnd_in),
    .cy_in   (flags_out[FB_CY]),
    .res     (res_out),
    .cy_out  (cy_next),
    .ac_out  (ac_next),
    .flag_wr (op_writes)
  );

  alu8_flaggen #(.DW(DW)) u_gen (
    .res   (res_out),
    .cy    (cy_next),
    .ac    (ac_next),
    .flags (flags_next)
  );

  alu8_flagreg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (flag_we),
    .d     (flags_next),
    .q     (flags_out)
  );

  // R6: increment/decrement keep carry
  p_cy_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op_code == 3'd4 || op_code == 3'd5))
      |=> (flags_out[FB_CY] == $past(flags_out[FB_CY])));

  // R7: zero flag tracks the written result
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_code <= 3'd5) |=> (flags_out[FB_Z] == ($past(res_out) == '0)));

  // R7: sign flag tracks the written result
  p_sign_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_code <= 3'd5) |=> (flags_out[FB_S] == $past(res_out[DW-1])));

  // R9: reserved codes pass the accumulator through
  p_rsv_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code >= 3'd6) |-> (res_out == acc_in));

endmodule

// File: tb/alu8_unit_tb_top.sv
module alu8_unit_tb_top;

  logic       clk;
  logic       rst_n;
  logic       exec_en;
  logic [2:0] op_code;
  logic [7:0] acc_in;
  logic [7:0] opnd_in;
  logic [7:0] res_out;
  logic [7:0] flags_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mdl_flags;

  alu8_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .res_out(res_out), .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected {result, flags} from the requirements
  function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic cy);
    int r, c, ac;
    logic [7:0] rb;
    c = cy; ac = 0; r = a;
    case (op)
      3'd0, 3'd1: begin
        int ci = (op == 3'd1) ? int'(cy) : 0;
        r  = int'(a) + int'(b) + ci;
        c  = (r > 255) ? 1 : 0;
        ac = (int'(a[3:0]) + int'(b[3:0]) + ci > 15) ? 1 : 0;
      end
      3'd2, 3'd3: begin
        int bi = (op == 3'd3) ? int'(cy) : 0;
        r  = int'(a) - int'(b) - bi + 256;
        c  = (int'(b) + bi > int'(a)) ? 1 : 0;
        ac = (int'(b[3:0]) + bi > int'(a[3:0])) ? 1 : 0;
      end
      3'd4: begin r = int'(b) + 1; ac = (b[3:0] == 4'hF) ? 1 : 0; end
      3'd5: begin r = int'(b) + 255; ac = (b[3:0] == 4'h0) ? 1 : 0; end
      default: r = a;
    endcase
    rb = r[7:0];
    return {rb, rb[7], (rb == 8'h00), 1'b0, ac[0], 1'b0, ~(^rb), 1'b1, c[0]};
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // drive one operation, check result before the edge and flags after it
  task automatic apply(input string req, input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic en);
    logic [15:0] e;
    @(negedge clk);
    exec_en = en; op_code = op; acc_in = a; opnd_in = b;
    #1;
    e = model(op, a, b, mdl_flags[0]);
    check(req, "result", res_out, e[15:8]);
    if (en && op <= 3'd5) mdl_flags = e[7:0];
    @(posedge clk); #1;
    check(req, "flags", flags_out, mdl_flags);
    exec_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; exec_en = 1'b0; op_code = 3'd0; acc_in = 8'h00; opnd_in = 8'h00;
    mdl_flags = 8'h02;
    repeat (3) @(posedge clk);
    #1 check("R1", "flags in reset", flags_out, 8'h02);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R1", "flags after reset", flags_out, 8'h02);
  endtask

  task automatic t_add();
    apply("R2", 3'd0, 8'h12, 8'h34, 1'b1);
    apply("R2", 3'd0, 8'h0F, 8'h01, 1'b1);
    apply("R2", 3'd0, 8'hFF, 8'h01, 1'b1);  // wraps to zero, CY and AC
    apply("R8", 3'd0, 8'h80, 8'h80, 1'b1);  // CY, Z, P at their bits
  endtask

  task automatic t_adc();
    apply("R3", 3'd0, 8'hF0, 8'h10, 1'b1);  // CY=1
    apply("R3", 3'd1, 8'h7F, 8'h00, 1'b1);  // 7F+0+1
    apply("R3", 3'd1, 8'h20, 8'h30, 1'b1);  // CY=0 now
  endtask

  task automatic t_sub();
    apply("R4", 3'd2, 8'h50, 8'h20, 1'b1);
    apply("R4", 3'd2, 8'h00, 8'h01, 1'b1);  // borrow, AC
    apply("R4", 3'd2, 8'h33, 8'h33, 1'b1);  // zero
  endtask

  task automatic t_sbb();
    apply("R5", 3'd2, 8'h00, 8'h01, 1'b1);  // CY=1
    apply("R5", 3'd3, 8'h10, 8'h0F, 1'b1);  // 10-0F-1 = 0
    apply("R5", 3'd2, 8'h01, 8'h02, 1'b1);  // CY=1
    apply("R5", 3'd3, 8'h42, 8'h42, 1'b1);  // equal operands with borrow
    apply("R5", 3'd3, 8'h42, 8'h02, 1'b1);  // CY was 1 -> 3F
  endtask

  task automatic t_incdec();
    apply("R6", 3'd0, 8'hFF, 8'hFF, 1'b1);  // CY=1
    apply("R6", 3'd4, 8'h00, 8'hFF, 1'b1);  // wrap, CY kept 1
    apply("R6", 3'd5, 8'h00, 8'h00, 1'b1);  // to FF, CY kept
    apply("R6", 3'd0, 8'h01, 8'h01, 1'b1);  // CY=0
    apply("R6", 3'd4, 8'h00, 8'h0F, 1'b1);  // AC, CY kept 0
    apply("R6", 3'd5, 8'h00, 8'h10, 1'b1);  // AC, CY kept 0
  endtask

  task automatic t_szp();
    apply("R7", 3'd0, 8'h01, 8'h02, 1'b1);  // 03, even parity
    apply("R7", 3'd0, 8'h01, 8'h06, 1'b1);  // 07, odd parity
    apply("R7", 3'd2, 8'h10, 8'h20, 1'b1);  // F0, sign
  endtask

  task automatic t_gate();
    apply("R9", 3'd0, 8'hFF, 8'h01, 1'b0);  // strobe low: no change
    apply("R9", 3'd6, 8'hA5, 8'hFF, 1'b1);  // reserved: pass acc, hold
    apply("R9", 3'd7, 8'h3C, 8'h01, 1'b1);
  endtask

  task automatic t_comb();
    @(negedge clk);
    exec_en = 1'b0; op_code = 3'd0; acc_in = 8'h10; opnd_in = 8'h01;
    #0.5 check("R10", "result same cycle", res_out, 8'h11);
    opnd_in = 8'h02;
    #0.5 check("R10", "result follows input", res_out, 8'h12);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_adc();
    t_sub();
    t_sbb();
    t_incdec();
    t_szp();
    t_gate();
    t_comb();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule